// File: doc/BRIEF.md
# Two-Address Clock Register Interface with Periodic Interrupt

The block puts a real-time-clock register file behind two bus addresses. A write to the index address picks one entry out of a single array. That array holds ten time bytes, control byte A, control byte B, status byte C, status byte D and a run of battery-style RAM bytes. A following access to the data address reads or writes the picked entry. After any data access the index falls back to status byte D. A stray read therefore yields a harmless constant.

A periodic timer counts a 32768 Hz tick enable and sets a flag in status byte C on every expiry. The timer's rate comes from the low nibble of byte A, and it runs only while the enable bit in byte B is set. The interrupt output gives a single-clock pulse on an expiry, unless an earlier expiry is still unacknowledged. Software acknowledges by reading byte C, which clears the flag and unblocks the line. The time bytes are plain storage: the block does not advance them.

Top module: `rtc_ixport`

## Requirements
- R1: An index-address write (acc_addr=0) loads the index. An index-address read returns 0xFF on acc_rdata and leaves the index unchanged.
- R2: An index write whose value exceeds TOTAL (14 + NVRAM_BYTES, 64 by default) selects status byte D (index 13) instead. The value TOTAL itself is accepted.
- R3: After every data-address access (acc_addr=1), read or write, the index is 13. A data read result appears on acc_rdata in the cycle after the access.
- R4: Data writes take effect only at indices 0 to 9 and 14 to TOTAL, plus bytes A (index 10) and B (index 11). Writes to C (12) and D (13) leave the values read back unchanged.
- R5: After reset the index is 13, byte A reads 0x00, byte B reads 0x06 (bit 1 = 24-hour, bit 2 = binary), byte C reads 0x00 and irq is low.
- R6: With RS = A[3:0] in the range 3 to 15 and B bit 6 set, an expiry happens on every 2^(RS-1)-th tick after the timer starts. With RS below 3 or B bit 6 clear, no expiry happens.
- R7: An expiry sets bit 6 of C. irq pulses high for exactly one clock, one cycle after the expiring tick, and only if no earlier expiry is waiting for acknowledgement.
- R8: A data read of C returns its current value, then clears bit 6 and the interrupt block. If an expiry falls in the same cycle, the expiry wins.
- R9: A data write to A or B restarts the timer count from zero, so the next expiry comes a full period after the write.
- R10: Byte D always reads 0x80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_32k | input | 1 | One-cycle enable at 32768 Hz |
| acc_valid | input | 1 | Bus access in this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 1 | 0 = index address, 1 = data address |
| acc_wdata | input | 8 | Write data |
| acc_rdata | output | 8 | Read data, valid the cycle after a read |
| irq | output | 1 | Periodic interrupt pulse |

## Verification
Directed sequences first separate the index path from the data path. They cover out-of-range and edge index values, index-address reads between selection and access, and writes to the read-only status bytes. These tell a correct fall-back to byte D apart from a stale index. Timer sequences vary RS across the lowest legal rate and an illegal value, and run two periods without acknowledgement to expose a missing block. They also rewrite byte A mid-period to tell a restart from a free-running count. A seeded random mix of accesses, rate changes and gapped ticks is then compared cycle by cycle against a bench model of flag, block and count.

// File: rtl/rtc_ixport.sv
module rtc_ixport #(
  parameter int NVRAM_BYTES = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_32k,
  input  logic       acc_valid,
  input  logic       acc_write,
  input  logic       acc_addr,
  input  logic [7:0] acc_wdata,
  output logic [7:0] acc_rdata,
  output logic       irq
);
  localparam int TOTAL = 14 + NVRAM_BYTES;
  localparam int IW    = $clog2(TOTAL + 1);
  localparam int CW    = 15;
  localparam logic [IW-1:0] IX_A = IW'(10);
  localparam logic [IW-1:0] IX_B = IW'(11);
  localparam logic [IW-1:0] IX_C = IW'(12);
  localparam logic [IW-1:0] IX_D = IW'(13);

  logic [7:0]    mem [0:TOTAL];
  logic [IW-1:0] idx;
  logic [CW-1:0] cnt;
  logic          pf, blk;

  wire        dsel    = acc_valid & acc_addr;
  wire        wr_d    = dsel & acc_write;
  wire        rd_d    = dsel & ~acc_write;
  wire [3:0]  rs      = mem[10][3:0];
  wire        active  = mem[11][6] && (rs >= 4'd3);
  wire        restart = wr_d && (idx == IX_A || idx == IX_B);
  wire [CW-1:0] per   = CW'(1) << (rs - 4'd1);
  wire        expire  = tick_32k && active && !restart && (cnt == per - CW'(1));
  wire        wr_ok   = (int'(idx) <= 11) || (int'(idx) >= 14);

  logic [7:0] rd_val;
  always_comb begin
    if (idx == IX_C)      rd_val = {1'b0, pf, 6'b0};
    else if (idx == IX_D) rd_val = 8'h80;
    else                  rd_val = mem[idx];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx       <= IX_D;
      cnt       <= '0;
      pf        <= 1'b0;
      blk       <= 1'b0;
      irq       <= 1'b0;
      acc_rdata <= 8'h00;
      for (int i = 0; i <= TOTAL; i++) mem[i] <= (i == 11) ? 8'h06 : 8'h00;
    end else begin
      irq <= expire && !blk;

      if (restart || !active) cnt <= '0;
      else if (tick_32k)      cnt <= expire ? '0 : cnt + CW'(1);

      if (rd_d && idx == IX_C) begin
        pf  <= 1'b0;
        blk <= 1'b0;
      end
      if (expire) begin
        pf  <= 1'b1;
        blk <= 1'b1;
      end

      if (acc_valid && !acc_addr) begin
        if (acc_write) idx <= (int'(acc_wdata) > TOTAL) ? IX_D : acc_wdata[IW-1:0];
        else           acc_rdata <= 8'hFF;
      end else if (dsel) begin
        if (acc_write && wr_ok) mem[idx] <= acc_wdata;
        if (!acc_write)         acc_rdata <= rd_val;
        idx <= IX_D;
      end
    end
  end
endmodule

// File: rtl/rtc_ixport_chk.sv
module rtc_ixport_chk #(
  parameter int TOTAL = 64,
  parameter int IW    = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_write,
  input logic          acc_addr,
  input logic          irq,
  input logic          blk,
  input logic          pf,
  input logic          expire,
  input logic [IW-1:0] idx
);
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);

  a_r7_blocked_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !$past(blk));

  a_r3_index_home: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr) |=> (int'(idx) == 13));

  a_r2_index_range: assert property (@(posedge clk) disable iff (!rst_n)
    int'(idx) <= TOTAL);

  a_r8_read_c_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_addr && !acc_write && int'(idx) == 12 && !expire) |=> (!pf && !blk));

  a_r7_expire_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> (pf && blk));
endmodule

bind rtc_ixport rtc_ixport_chk #(.TOTAL(TOTAL), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .irq(irq), .blk(blk), .pf(pf), .expire(expire), .idx(idx)
);

// File: tb/rtc_ixport_tb.sv
`timescale 1ns/1ps
module rtc_ixport_tb;
  localparam int TOTAL = 64;

  logic clk = 0, rst_n = 0, tick_32k = 0;
  logic acc_valid = 0, acc_write = 0, acc_addr = 0;
  logic [7:0] acc_wdata = 0;
  logic [7:0] acc_rdata;
  logic irq;

  int total = 0, bad = 0, pulses = 0;

  int m_mem [0:TOTAL];
  int m_idx, m_cnt;
  bit m_pf, m_blk;

  always #2.5 clk = ~clk;

  rtc_ixport u_dut (.clk(clk), .rst_n(rst_n), .tick_32k(tick_32k), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .acc_rdata(acc_rdata), .irq(irq));

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int model_rd(int i);
    if (i == 12) return m_pf ? 8'h40 : 0;
    if (i == 13) return 8'h80;
    return m_mem[i];
  endfunction

  task automatic model_reset();
    for (int i = 0; i <= TOTAL; i++) m_mem[i] = (i == 11) ? 8'h06 : 0;
    m_idx = 13; m_cnt = 0; m_pf = 0; m_blk = 0;
  endtask

  task automatic cyc(bit v, bit w, bit a, logic [7:0] d, bit t, string tag);
    int rs, per, exp_rd;
    bit act, rst_c, ex, exp_irq, chk_rd;
    acc_valid = v; acc_write = w; acc_addr = a; acc_wdata = d; tick_32k = t;
    rs = m_mem[10] & 15;
    act = ((m_mem[11] >> 6) & 1) == 1 && rs >= 3;
    per = (rs >= 1) ? (1 << (rs - 1)) : 1;
    rst_c = v && a && w && (m_idx == 10 || m_idx == 11);
    ex = t && act && !rst_c && (m_cnt == per - 1);
    exp_irq = ex && !m_blk;
    chk_rd = v && !w;
    exp_rd = a ? model_rd(m_idx) : 8'hFF;
    if (rst_c || !act) m_cnt = 0;
    else if (t) m_cnt = ex ? 0 : m_cnt + 1;
    if (v && a && !w && m_idx == 12) begin m_pf = 0; m_blk = 0; end
    if (ex) begin m_pf = 1; m_blk = 1; end
    if (v && !a && w) m_idx = (int'(d) > TOTAL) ? 13 : int'(d);
    else if (v && a) begin
      if (w && (m_idx <= 11 || m_idx >= 14)) m_mem[m_idx] = int'(d);
      m_idx = 13;
    end
    @(posedge clk); #1;
    check(irq == exp_irq, {tag, " R7 irq"}, irq, exp_irq);
    if (chk_rd) check(acc_rdata == exp_rd[7:0], {tag, " rdata"}, acc_rdata, exp_rd);
    if (irq) pulses++;
    acc_valid = 0; tick_32k = 0;
  endtask

  task automatic put(int i, int val, string tag);
    cyc(1, 1, 0, 8'(i), 0, tag);
    cyc(1, 1, 1, 8'(val), 0, tag);
  endtask

  task automatic rdchk(int i, int exp, string tag);
    cyc(1, 1, 0, 8'(i), 0, tag);
    cyc(1, 0, 1, 8'h00, 0, tag);
    check(acc_rdata == exp[7:0], tag, acc_rdata, exp);
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) cyc(0, 0, 0, 8'h00, 1, "ticks");
  endtask

  initial begin
    #(5.0 * 190000);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int p0;
    model_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    check(irq == 0, "R5 irq after reset", irq, 0);
    cyc(1, 0, 1, 8'h00, 0, "R5");
    check(acc_rdata == 8'h80, "R5 R10 index at D after reset", acc_rdata, 8'h80);
    rdchk(11, 8'h06, "R5 byte B reset");
    rdchk(10, 8'h00, "R5 byte A reset");
    rdchk(12, 8'h00, "R5 byte C reset");

    put(20, 8'h5A, "R1");
    cyc(1, 1, 0, 8'd20, 0, "R1");
    cyc(1, 0, 0, 8'h00, 0, "R1");
    check(acc_rdata == 8'hFF, "R1 index read", acc_rdata, 8'hFF);
    cyc(1, 0, 1, 8'h00, 0, "R1");
    check(acc_rdata == 8'h5A, "R1 index kept", acc_rdata, 8'h5A);

    rdchk(200, 8'h80, "R2 out-of-range index");
    put(TOTAL, 8'h33, "R2");
    rdchk(TOTAL, 8'h33, "R2 top index");
    cyc(1, 0, 1, 8'h00, 0, "R3");
    check(acc_rdata == 8'h80, "R3 index home after read", acc_rdata, 8'h80);
    put(5, 8'h11, "R3");
    cyc(1, 1, 1, 8'h77, 0, "R3");
    rdchk(5, 8'h11, "R3 second write hit D");

    put(9, 8'h99, "R4");
    rdchk(9, 8'h99, "R4 year written");
    put(12, 8'h40, "R4");
    rdchk(12, 8'h00, "R4 C write ignored");
    put(13, 8'h00, "R4");
    rdchk(13, 8'h80, "R4 R10 D write ignored");

    put(10, 8'h21, "R6");
    put(11, 8'h46, "R6");
    p0 = pulses; ticks(100);
    check(pulses == p0, "R6 RS=1 silent", pulses - p0, 0);
    put(10, 8'h23, "R6");
    p0 = pulses; ticks(3);
    check(pulses == p0, "R6 before 4th tick", pulses - p0, 0);
    ticks(1); ticks(1);
    check(pulses == p0 + 1, "R6 R7 pulse at 4th tick", pulses - p0, 1);
    p0 = pulses; ticks(12);
    check(pulses == p0, "R7 blocked until C read", pulses - p0, 0);
    rdchk(12, 8'h40, "R8 C shows flag");
    rdchk(12, 8'h00, "R8 flag cleared");
    p0 = pulses; ticks(5);
    check(pulses == p0 + 1, "R8 re-armed", pulses - p0, 1);
    rdchk(12, 8'h40, "R8 ack");

    put(10, 8'h24, "R9");
    p0 = pulses; ticks(6);
    put(10, 8'h24, "R9");
    ticks(7);
    check(pulses == p0, "R9 no pulse after restart", pulses - p0, 0);
    ticks(2);
    check(pulses == p0 + 1, "R9 full period after write", pulses - p0, 1);
    rdchk(12, 8'h40, "R9 ack");
    put(11, 8'h06, "R6");
    p0 = pulses; ticks(40);
    check(pulses == p0, "R6 enable clear silent", pulses - p0, 0);

    for (int n = 0; n < 4000; n++) begin
      int i, dv;
      i = $urandom_range(0, 70);
      dv = $urandom_range(0, 255);
      if (i == 10) dv = 8'h20 | $urandom_range(0, 6);
      case ($urandom_range(0, 5))
        0: cyc(1, 1, 0, 8'(i), $urandom_range(0, 3) != 0, "rand R2");
        1: cyc(1, 1, 1, 8'(dv), $urandom_range(0, 3) != 0, "rand R4");
        2: cyc(1, 0, 1, 8'h00, $urandom_range(0, 3) != 0, "rand R3");
        3: cyc(1, 0, 0, 8'h00, $urandom_range(0, 3) != 0, "rand R1");
        4: begin cyc(1, 1, 0, 8'd12, 1, "rand R8"); cyc(1, 0, 1, 8'h00, 1, "rand R8"); end
        default: cyc(0, 0, 0, 8'h00, $urandom_range(0, 3) != 0, "rand R6");
      endcase
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial void'($urandom(32'd17));
endmodule